// File: doc/BRIEF.md
# External SRAM Interface Test Sequencer

This block exercises an asynchronous 8K x 8 static RAM that sits outside the chip. It looks for address and data lines that are stuck or shorted, and it checks that the memory's control pins behave correctly. It drives a 13-bit address, a pair of chip selects (`mem_sel_hi` is active high and `mem_sel_lo_n` is active low), an active-low output enable and an active-low write enable. The data bus leaves the block as a driven value plus a drive-enable, and the bus level comes back in on `dq_in`, where the pad logic resolves it with a pull-up.

A one-cycle `start` launches a fixed sequence of 75 bus steps, numbered 0 to 74. Each step lasts `PERIOD` clocks. A read step samples the bus at phase `SAMPLE`. The sequence has five phases:

- Steps 0-13 write a thermometer pattern.
- Steps 14-27 read that pattern back.
- Steps 28-59 write and read each data pin on its own.
- Steps 60-71 try writes that must not land, and read back to confirm.
- Steps 72-74 check that the bus floats while output enable is inactive.

The first read that does not match stops the sequence. The block then reports failure and the number of the failing step. If every step matches, it reports a pass.

Top module: `sramchk_top`

## Requirements
- R1: After reset, and whenever no sequence is running, the pins sit at their idle state: address 0, `(mem_sel_hi, mem_sel_lo_n) = (0,1)`, output enable low, write enable high, data drive off. `busy` and `done` are both low after reset.
- R2: The memory counts as selected only for `(mem_sel_hi, mem_sel_lo_n) = (1,0)`. In steps 61, 64 and 67 the block attempts a write of FF to address 0 with write enable low and the codes (0,1), (1,1) and (0,0) respectively. A correct memory stores nothing in any of these steps.
- R3: Steps 0-13 write the addresses 0x0000, 0x0001, 0x0003 and so on, each with one more low-order one, up to 0x1FFF. The data, in the same order, is 01, 03, 07, 0F, 1F, 3F, 7F, FF, FE, FC, F8, F0, E0, C0 (hex).
- R4: All 14 pattern writes finish before the first read. Step 14+i reads the address of step i and compares the full byte with the data of step i.
- R5: Each step lasts `PERIOD` clocks. In a write step, write enable is low for exactly `SAMPLE-WE_START` clocks. Address, selects and driven data stay constant while write enable is low, and the data is driven for the whole step.
- R6: Data is driven only during write steps, and never while output enable is low. Read data is sampled at phase `SAMPLE` of the step.
- R7: Steps 28-59 handle bit b = 0..7 in groups of four, at steps 28+4b to 31+4b. The four steps are: write 00 to address 0, read it checking only bit b, write (1<<b), read it checking only bit b.
- R8: Steps 60-71 form four groups of three steps: write 00 to address 0, make the attempt, then read address 0 expecting 00. The attempts are the three deselect codes of R2, and then a selected write with write enable held high (step 70).
- R9: Step 72 writes 00 to address 0. Step 73 reads with the memory selected and output enable high, and expects FF from the bus pull-up. Step 74 reads with output enable low and expects 00.
- R10: The first mismatch latches failure and records the step number in `fail_step`. `busy` drops one cycle after the sample point (`fail_step*PERIOD+SAMPLE+1` clocks after the `start` edge), and the pins return to idle.
- R11: `done` is high with `pass` = 1 exactly `75*PERIOD` clocks after the `start` edge when every step matches. The result holds until the next `start`, which restarts the sequence from step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the sequence (ignored while busy) |
| dq_in | input | 8 | Resolved level of the memory data bus |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished, result valid |
| pass | output | 1 | All steps matched (valid with done) |
| fail_step | output | 7 | Number of the first failing step |
| mem_addr | output | 13 | Memory address |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_sel_lo_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Data drive enable |

## Verification
A wrong step index or wrong decoded step data shows up as a misordered or wrong write, seen at the memory pins within the same step. It also shows up as a false `fail_step`, one cycle after the sample point of the affected read. A phase counter that drifts changes the write-enable pulse width and the step spacing in the very first write. It also moves the cycle in which `done` rises. A stuck state bit either leaves `busy` and `done` both high, or leaves the pins away from idle after completion. Either condition is visible within one step.

// File: rtl/sramchk_pkg.sv
package sramchk_pkg;
  localparam int AW       = 13;
  localparam int DW       = 8;
  localparam int NPAT     = AW + 1;
  localparam int BASE_RD  = NPAT;
  localparam int BASE_PIN = 2 * NPAT;
  localparam int BASE_NEG = BASE_PIN + 4 * DW;
  localparam int BASE_OE  = BASE_NEG + 12;
  localparam int NSTEP    = BASE_OE + 3;
  localparam int IW       = $clog2(NSTEP);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;

  typedef struct packed {
    logic          is_wr;
    logic          we_act;
    logic          sel_hi;
    logic          sel_lo_n;
    logic          rd_oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [DW-1:0] mask;
  } step_t;

  // address with i low-order ones
  function automatic logic [AW-1:0] therm_addr(input int i);
    logic [AW-1:0] ones;
    ones = '1;
    if (i <= 0) return '0;
    return ones >> (AW - i);
  endfunction

  // rising run of ones, then ones shifting out at the bottom
  function automatic logic [DW-1:0] pat_data(input int i);
    logic [DW-1:0] ones;
    ones = '1;
    if (i < DW) return ones >> (DW - 1 - i);
    return ones << (i - DW + 1);
  endfunction

  function automatic step_t decode_step(input logic [IW-1:0] idx);
    step_t s;
    int n, j, b, k, m;
    n = int'(idx);
    s = '0;
    s.sel_hi = 1'b1;
    s.mask   = '1;
    if (n < BASE_RD) begin
      s.is_wr  = 1'b1;
      s.we_act = 1'b1;
      s.addr   = therm_addr(n);
      s.data   = pat_data(n);
    end else if (n < BASE_PIN) begin
      s.addr = therm_addr(n - BASE_RD);
      s.data = pat_data(n - BASE_RD);
    end else if (n < BASE_NEG) begin
      j = n - BASE_PIN;
      b = j / 4;
      s.mask   = DW'(1) << b;
      s.data   = ((j % 4) >= 2) ? (DW'(1) << b) : '0;
      s.is_wr  = ((j % 4) == 0) || ((j % 4) == 2);
      s.we_act = s.is_wr;
    end else if (n < BASE_OE) begin
      k = (n - BASE_NEG) / 3;
      m = (n - BASE_NEG) % 3;
      if (m == 0) begin
        s.is_wr  = 1'b1;
        s.we_act = 1'b1;
      end else if (m == 1) begin
        s.is_wr  = 1'b1;
        s.we_act = 1'b1;
        s.data   = '1;
        case (k)
          0:       begin s.sel_hi = 1'b0; s.sel_lo_n = 1'b1; end
          1:       begin s.sel_hi = 1'b1; s.sel_lo_n = 1'b1; end
          2:       begin s.sel_hi = 1'b0; s.sel_lo_n = 1'b0; end
          default: s.we_act = 1'b0;
        endcase
      end
    end else begin
      m = n - BASE_OE;
      if (m == 0) begin
        s.is_wr  = 1'b1;
        s.we_act = 1'b1;
      end else if (m == 1) begin
        s.rd_oe_n = 1'b1;
        s.data    = '1;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/sramchk_timer.sv
module sramchk_timer #(
  parameter int PERIOD   = 50,
  parameter int SAMPLE   = 40,
  parameter int WE_START = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph_sample,
  output logic ph_last,
  output logic we_win
);
  localparam int TW = $clog2(PERIOD);

  logic [TW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase <= '0;
    else if (!run)                        phase <= '0;
    else if (phase == TW'(PERIOD - 1))    phase <= '0;
    else                                  phase <= phase + 1'b1;
  end

  assign ph_sample = run && (phase == TW'(SAMPLE));
  assign ph_last   = run && (phase == TW'(PERIOD - 1));
  assign we_win    = (phase >= TW'(WE_START)) && (phase < TW'(SAMPLE));
endmodule

// File: rtl/sramchk_seq.sv
module sramchk_seq
  import sramchk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ph_sample,
  input  logic          ph_last,
  input  logic [DW-1:0] dq_in,
  output step_t         step,
  output logic          mismatch,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [IW-1:0] fail_step
);
  seq_state_e    state;
  logic [IW-1:0] idx;
  logic          failed;

  assign step     = decode_step(idx);
  assign mismatch = ph_sample && !step.is_wr &&
                    (((dq_in ^ step.data) & step.mask) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      failed    <= 1'b0;
      fail_step <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (mismatch) begin
            failed    <= 1'b1;
            fail_step <= idx;
            state     <= ST_DONE;
          end else if (ph_last) begin
            if (idx == IW'(NSTEP - 1)) state <= ST_DONE;
            else                       idx   <= idx + 1'b1;
          end
        end
        default: begin
          if (start) begin
            state     <= ST_RUN;
            idx       <= '0;
            failed    <= 1'b0;
            fail_step <= '0;
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);
  assign pass = done && !failed;
endmodule

// File: rtl/sramchk_pins.sv
module sramchk_pins
  import sramchk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  step_t         step,
  input  logic          we_win,
  output logic [AW-1:0] addr,
  output logic          sel_hi,
  output logic          sel_lo_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !active) begin
      addr     <= '0;
      sel_hi   <= 1'b0;
      sel_lo_n <= 1'b1;
      oe_n     <= 1'b0;
      we_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      addr     <= step.addr;
      sel_hi   <= step.sel_hi;
      sel_lo_n <= step.sel_lo_n;
      if (step.is_wr) begin
        oe_n   <= 1'b1;
        we_n   <= !(step.we_act && we_win);
        dq_out <= step.data;
        dq_oe  <= 1'b1;
      end else begin
        oe_n   <= step.rd_oe_n;
        we_n   <= 1'b1;
        dq_out <= '0;
        dq_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sramchk_top.sv
module sramchk_top
  import sramchk_pkg::*;
#(
  parameter int PERIOD   = 50,
  parameter int SAMPLE   = 40,
  parameter int WE_START = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [IW-1:0] fail_step,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_hi,
  output logic          mem_sel_lo_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  logic  ph_sample, ph_last, we_win, mismatch;
  step_t step;

  sramchk_timer #(.PERIOD(PERIOD), .SAMPLE(SAMPLE), .WE_START(WE_START)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .ph_sample(ph_sample), .ph_last(ph_last), .we_win(we_win)
  );

  sramchk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ph_sample(ph_sample), .ph_last(ph_last), .dq_in(dq_in),
    .step(step), .mismatch(mismatch),
    .busy(busy), .done(done), .pass(pass), .fail_step(fail_step)
  );

  sramchk_pins u_pins (
    .clk(clk), .rst_n(rst_n), .active(busy), .step(step), .we_win(we_win),
    .addr(mem_addr), .sel_hi(mem_sel_hi), .sel_lo_n(mem_sel_lo_n),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/sramchk_chk.sv
module sramchk_chk
  import sramchk_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [IW-1:0] fail_step,
  input logic          mismatch,
  input logic [AW-1:0] addr,
  input logic          sel_hi,
  input logic          sel_lo_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (we_n && !dq_oe && !sel_hi && sel_lo_n && !oe_n && addr == '0));

  p_drive_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  p_we_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !$past(we_n)) |-> ($stable(addr) && $stable(dq_out) && $stable(sel_hi) && $stable(sel_lo_n)));

  p_fail_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (done && !pass && !busy));

  p_state_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail_step) && $stable(pass)));
endmodule

bind sramchk_top sramchk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail_step(fail_step), .mismatch(mismatch),
  .addr(mem_addr), .sel_hi(mem_sel_hi), .sel_lo_n(mem_sel_lo_n),
  .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
);

// File: tb/tb_sramchk_top.sv
module tb_sramchk_top;
  localparam int PER = 50;
  localparam int SMP = 40;
  localparam int WES = 2;
  localparam int STEPS = 75;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  dq_in = 8'hFF;
  logic        busy, done, pass;
  logic [6:0]  fail_step;
  logic [12:0] mem_addr;
  logic        mem_sel_hi, mem_sel_lo_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;

  always #10 clk = ~clk;

  sramchk_top #(.PERIOD(PER), .SAMPLE(SMP), .WE_START(WES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dq_in(dq_in),
    .busy(busy), .done(done), .pass(pass), .fail_step(fail_step),
    .mem_addr(mem_addr), .mem_sel_hi(mem_sel_hi), .mem_sel_lo_n(mem_sel_lo_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  typedef struct {
    int    a;
    int    d;
    string req;
  } wr_item_t;

  wr_item_t   exp_q[$];
  logic [7:0] mem [int];
  int n_chk = 0, n_bad = 0;
  int fault = 0;
  bit sb_en = 1'b0;
  bit finished = 1'b0;
  int cyc = 0, low_cnt = 0, fall_num = 0, desel_cnt = 0, oe_viol = 0;
  int fall_t [64];
  int fall_addr = 0;
  logic prev_we_n = 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: every selected write of a clean run
  task automatic push_expected();
    wr_item_t it;
    exp_q.delete();
    for (int i = 0; i < 14; i++) begin
      it.a = (1 << i) - 1;
      it.d = (i < 8) ? ((1 << (i + 1)) - 1) : ((255 << (i - 7)) & 255);
      it.req = "R3";
      exp_q.push_back(it);
    end
    for (int b = 0; b < 8; b++) begin
      it.a = 0; it.d = 0;        it.req = "R7"; exp_q.push_back(it);
      it.a = 0; it.d = (1 << b); it.req = "R7"; exp_q.push_back(it);
    end
    for (int k = 0; k < 5; k++) begin
      it.a = 0; it.d = 0; it.req = (k < 4) ? "R8" : "R9";
      exp_q.push_back(it);
    end
  endtask

  function automatic logic [7:0] mem_rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  // behavioural memory with pull-up, plus the write monitor
  always @(negedge clk) begin
    logic [7:0] bus, d;
    logic sel_t, sel_w;
    int ea;
    wr_item_t it;
    cyc++;
    sel_t = mem_sel_hi && !mem_sel_lo_n;
    sel_w = (fault == 3) ? 1'b1 : ((fault == 4) ? mem_sel_hi : sel_t);
    ea = (fault == 2) ? int'(mem_addr & 13'h0FFF) : int'(mem_addr);
    if (start) begin
      fall_num = 0;
      desel_cnt = 0;
      oe_viol = 0;
    end
    if (rst_n) begin
      if (prev_we_n && !mem_we_n) begin
        low_cnt = 0;
        fall_addr = int'(mem_addr);
        if (fall_num < 64) fall_t[fall_num] = cyc;
        fall_num++;
      end
      if (!mem_we_n) low_cnt++;
      if (!prev_we_n && mem_we_n) begin
        chk("R5", "write enable low width", low_cnt, SMP - WES);
        chk("R5", "address held during write", int'(mem_addr), fall_addr);
        if (!sel_t) desel_cnt++;
        if (sel_w) begin
          d = mem_dq_oe ? mem_dq_out : 8'hFF;
          if (fault == 1) d = d & ~8'h08;
          if (fault == 6 && ea == 0) d = d & ~8'h40;
          mem[ea] = d;
        end
        if (sel_t && sb_en) begin
          if (exp_q.size() == 0) chk("R3", "unexpected selected write", 1, 0);
          else begin
            it = exp_q.pop_front();
            chk(it.req, "write address", int'(mem_addr), it.a);
            chk(it.req, "write data", int'(mem_dq_out), it.d);
          end
        end
      end
      if (mem_dq_oe && !mem_oe_n) oe_viol++;
    end
    prev_we_n = mem_we_n;
    if (mem_dq_oe) bus = mem_dq_out;
    else if (sel_t && mem_we_n && (fault == 5 || !mem_oe_n)) bus = mem_rd(ea);
    else bus = 8'hFF;
    dq_in <= bus;
  end

  task automatic check_idle(input string req);
    chk(req, "idle address", int'(mem_addr), 0);
    chk(req, "idle selects", int'({mem_sel_hi, mem_sel_lo_n}), 1);
    chk(req, "idle oe_n", int'(mem_oe_n), 0);
    chk(req, "idle we_n", int'(mem_we_n), 1);
    chk(req, "idle drive", int'(mem_dq_oe), 0);
  endtask

  task automatic run_seq(input int f, input int exp_pass, input int exp_step, input string req);
    int n;
    fault = f;
    sb_en = (f == 0);
    mem.delete();
    if (sb_en) push_expected();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 10000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(req, "done after run", int'(done), 1);
    chk(req, "pass flag", int'(pass), exp_pass);
    chk("R10", "busy low when finished", int'(busy), 0);
    if (exp_pass == 0) begin
      chk(req, "failing step", int'(fail_step), exp_step);
      chk("R10", "cycles to stop", n, exp_step * PER + SMP + 1);
    end else begin
      chk("R11", "cycles to complete", n, STEPS * PER);
      chk("R3", "scoreboard drained", exp_q.size(), 0);
      chk("R6", "drive with output enable low", oe_viol, 0);
      chk("R2", "deselected write attempts", desel_cnt, 3);
      for (int i = 1; i < 14; i++)
        chk("R5", "write step spacing", fall_t[i] - fall_t[i-1], PER);
    end
    @(negedge clk);
    check_idle("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    check_idle("R1");
    run_seq(0, 1, 0, "R11");
    run_seq(1, 0, 17, "R4");
    run_seq(2, 0, 26, "R4");
    run_seq(6, 0, 55, "R7");
    run_seq(3, 0, 62, "R8");
    run_seq(4, 0, 65, "R2");
    run_seq(5, 0, 73, "R9");
    run_seq(0, 1, 0, "R11");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule